// File: doc/BRIEF.md
# Bank Open-Row Tracker

This block sits in the front end of a DDR3/DDR4 memory controller. It keeps, for every bank, a flag saying whether a row is open and the number of that row. Each incoming request address is split into bank group, bank, row and column. The request is then sorted into one of three classes: a hit on the open row, a conflict with a different open row, or an access to a closed bank.

From the class the block issues the shortest command sequence that serves the request. A hit gets only the read or write. A closed bank gets an activate followed by the access. A conflict gets a precharge, an activate and then the access. The bank table changes only when the block itself issues an activate or a precharge. A precharge-all input closes every bank at once. Both geometries come from one static mode input. In DDR4 mode there are 16 banks, addressed as 4 groups of 4. In DDR3 mode there are 8 banks. Because open rows are reused, back-to-back hits go out at one access per cycle.

Top module: `bank_row_tracker`

## Requirements
- R1: The request address is laid out as {row[ROW_W-1:0], bank_field[3:0], col[COL_W-1:0]}. In DDR4 mode (`geo_ddr4_i`=1), bank_field[3:2] is the bank group and bank_field[1:0] the bank within the group, giving bank index group*4+bank = bank_field (0..15).
- R2: In DDR3 mode (`geo_ddr4_i`=0) the bank index is bank_field[2:0] (0..7). bank_field[3] is ignored, so two addresses that differ only in that bit reach the same bank.
- R3: A request whose bank is open on the same row reports class 1 (hit) on `req_class_o`. The block then issues a single access command in the cycle after acceptance: 3 = read, 4 = write. That command carries the request's bank and column.
- R4: A request to a closed bank reports class 3. The block then issues an activate (code 1) carrying the bank and row, followed in the next cycle by the access.
- R5: A request whose bank holds a different open row reports class 2. The block then issues a precharge (code 2) to that bank, then an activate with the new row, then the access, on three consecutive cycles.
- R6: Each bank keeps its own state. Opening, closing or switching the row in one bank leaves the open row of every other bank unchanged.
- R7: While `prechg_all_i` is high, `req_ready_o` is low. At the next clock edge every bank becomes closed.
- R8: `hit_cnt_o` counts accepted hits and `miss_cnt_o` counts accepted row conflicts. Accesses to closed banks change neither counter.
- R9: After reset every bank is closed, `cmd_o` is 0 (no command), `req_ready_o` is 1 and both counters are 0. `req_class_o` is 0 while `req_valid_i` is low.
- R10: `req_ready_o` is low during precharge and activate cycles and high during access cycles. A hit can therefore be accepted in the same cycle as the previous request's access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| geo_ddr4_i | input | 1 | 1 = 16-bank grouped geometry, 0 = 8-bank geometry |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ROW_W+4+COL_W | Request address {row, bank field, column} |
| prechg_all_i | input | 1 | Close all banks |
| req_ready_o | output | 1 | Request accepted at this edge when valid |
| req_class_o | output | 2 | 0 none, 1 hit, 2 row conflict, 3 closed bank |
| cmd_o | output | 3 | 0 none, 1 activate, 2 precharge, 3 read, 4 write |
| cmd_bank_o | output | 4 | Bank index of the command |
| cmd_row_o | output | ROW_W | Row of the command |
| cmd_col_o | output | COL_W | Column of the command |
| hit_cnt_o | output | CNT_W | Accepted hits |
| miss_cnt_o | output | CNT_W | Accepted row conflicts |

## Verification
Two cases are hard to reach from the ports. The first is a request accepted during the access cycle of the previous one. The stimulus opens two banks first, then keeps valid high across the access cycle with a second hit queued, so the lookup must see the table the earlier activate just updated. The second is precharge-all arriving while a request is waiting. The bench holds a request valid through the precharge-all cycle and checks that it is refused. It then checks that formerly open banks come back as closed and need a fresh activate. The DDR3 aliasing of the top bank-field bit is shown by opening a bank through one alias and hitting it through the other.

// File: rtl/brt_pkg.sv
package brt_pkg;
  localparam int BANK_FIELD_W = 4;
  localparam int NUM_BANKS    = 1 << BANK_FIELD_W;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_HIT    = 2'd1,
    CLS_CONF   = 2'd2,
    CLS_CLOSED = 2'd3
  } cls_e;
endpackage

// File: rtl/brt_addr_decode.sv
module brt_addr_decode
  import brt_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 10,
  localparam int ADDR_W = ROW_W + BANK_FIELD_W + COL_W
) (
  input  logic                    geo_ddr4_i,
  input  logic [ADDR_W-1:0]       addr_i,
  output logic [BANK_FIELD_W-1:0] bank_o,
  output logic [ROW_W-1:0]        row_o,
  output logic [COL_W-1:0]        col_o
);
  logic [BANK_FIELD_W-1:0] field;

  assign col_o = addr_i[COL_W-1:0];
  assign field = addr_i[COL_W +: BANK_FIELD_W];
  assign row_o = addr_i[ADDR_W-1 -: ROW_W];

  // grouped: {group, bank} is already the flat index; 8-bank: top bit ignored
  assign bank_o = geo_ddr4_i ? field : {1'b0, field[BANK_FIELD_W-2:0]};
endmodule

// File: rtl/brt_bank_table.sv
module brt_bank_table
  import brt_pkg::*;
#(
  parameter int ROW_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    act_i,
  input  logic                    pre_i,
  input  logic [BANK_FIELD_W-1:0] upd_bank_i,
  input  logic [ROW_W-1:0]        upd_row_i,
  input  logic                    pall_i,
  input  logic [BANK_FIELD_W-1:0] lk_bank_i,
  output logic                    lk_open_o,
  output logic [ROW_W-1:0]        lk_row_o
);
  logic [NUM_BANKS-1:0] open_q;
  logic [ROW_W-1:0]     row_q [NUM_BANKS];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = (upd_bank_i == BANK_FIELD_W'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        open_q[b] <= 1'b0;
        row_q[b]  <= '0;
      end else if (act_i && sel) begin
        // an activate issued this cycle outranks precharge-all
        open_q[b] <= 1'b1;
        row_q[b]  <= upd_row_i;
      end else if (pall_i || (pre_i && sel)) begin
        open_q[b] <= 1'b0;
      end
    end
  end

  assign lk_open_o = open_q[lk_bank_i];
  assign lk_row_o  = row_q[lk_bank_i];

  p_act_closed_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> !open_q[upd_bank_i]);
  p_pre_open_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q[upd_bank_i]);
  p_pall_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pall_i && !act_i) |=> (open_q == '0));
  p_act_opens_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> ($countones(open_q) == $countones($past(open_q)) + 1));
endmodule

// File: rtl/brt_cmd_seq.sv
module brt_cmd_seq
  import brt_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 10,
  parameter int CNT_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [BANK_FIELD_W-1:0] req_bank_i,
  input  logic [ROW_W-1:0]        req_row_i,
  input  logic [COL_W-1:0]        req_col_i,
  input  logic                    lk_open_i,
  input  logic [ROW_W-1:0]        lk_row_i,
  input  logic                    prechg_all_i,
  output logic                    req_ready_o,
  output cls_e                    req_class_o,
  output cmd_e                    cmd_o,
  output logic [BANK_FIELD_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]        cmd_row_o,
  output logic [COL_W-1:0]        cmd_col_o,
  output logic                    act_o,
  output logic                    pre_o,
  output logic [CNT_W-1:0]        hit_cnt_o,
  output logic [CNT_W-1:0]        miss_cnt_o
);
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_ACT, ST_ACC} st_e;

  st_e                     st_q, st_d;
  logic [BANK_FIELD_W-1:0] bank_q;
  logic [ROW_W-1:0]        row_q;
  logic [COL_W-1:0]        col_q;
  logic                    wr_q;
  cls_e                    cls;
  logic                    accept;

  always_comb begin
    if (!req_valid_i)               cls = CLS_NONE;
    else if (!lk_open_i)            cls = CLS_CLOSED;
    else if (lk_row_i == req_row_i) cls = CLS_HIT;
    else                            cls = CLS_CONF;
  end

  assign req_class_o = cls;
  assign req_ready_o = ((st_q == ST_IDLE) || (st_q == ST_ACC)) && !prechg_all_i;
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_PRE:  st_d = ST_ACT;
      ST_ACT:  st_d = ST_ACC;
      default: st_d = ST_IDLE;
    endcase
    if (accept) begin
      unique case (cls)
        CLS_HIT:  st_d = ST_ACC;
        CLS_CONF: st_d = ST_PRE;
        default:  st_d = ST_ACT;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      bank_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
      wr_q       <= 1'b0;
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        bank_q <= req_bank_i;
        row_q  <= req_row_i;
        col_q  <= req_col_i;
        wr_q   <= req_write_i;
        if (cls == CLS_HIT)  hit_cnt_o  <= hit_cnt_o + 1'b1;
        if (cls == CLS_CONF) miss_cnt_o <= miss_cnt_o + 1'b1;
      end
    end
  end

  always_comb begin
    unique case (st_q)
      ST_PRE:  cmd_o = CMD_PRE;
      ST_ACT:  cmd_o = CMD_ACT;
      ST_ACC:  cmd_o = wr_q ? CMD_WR : CMD_RD;
      default: cmd_o = CMD_NOP;
    endcase
  end

  assign cmd_bank_o = bank_q;
  assign cmd_row_o  = row_q;
  assign cmd_col_o  = col_q;
  assign act_o      = (st_q == ST_ACT);
  assign pre_o      = (st_q == ST_PRE);

  p_pre_then_act_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_PRE) |=> (cmd_o == CMD_ACT));
  p_act_then_access_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o == CMD_ACT) |=> (cmd_o == CMD_RD || cmd_o == CMD_WR));
  p_hit_access_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_class_o == CLS_HIT) |=>
      (cmd_o == CMD_RD || cmd_o == CMD_WR));
  p_cnt_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 ((hit_cnt_o - $past(hit_cnt_o)) <= CNT_W'(1) &&
         (miss_cnt_o - $past(miss_cnt_o)) <= CNT_W'(1)));
endmodule

// File: rtl/bank_row_tracker.sv
module bank_row_tracker
  import brt_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int COL_W = 10,
  parameter int CNT_W = 16,
  localparam int ADDR_W = ROW_W + BANK_FIELD_W + COL_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    geo_ddr4_i,
  input  logic                    req_valid_i,
  input  logic                    req_write_i,
  input  logic [ADDR_W-1:0]       req_addr_i,
  input  logic                    prechg_all_i,
  output logic                    req_ready_o,
  output logic [1:0]              req_class_o,
  output logic [2:0]              cmd_o,
  output logic [BANK_FIELD_W-1:0] cmd_bank_o,
  output logic [ROW_W-1:0]        cmd_row_o,
  output logic [COL_W-1:0]        cmd_col_o,
  output logic [CNT_W-1:0]        hit_cnt_o,
  output logic [CNT_W-1:0]        miss_cnt_o
);
  logic [BANK_FIELD_W-1:0] dec_bank;
  logic [ROW_W-1:0]        dec_row;
  logic [COL_W-1:0]        dec_col;
  logic                    lk_open;
  logic [ROW_W-1:0]        lk_row;
  logic                    act, pre;
  cls_e                    cls;
  cmd_e                    cmd;

  brt_addr_decode #(.ROW_W(ROW_W), .COL_W(COL_W)) u_dec (
    .geo_ddr4_i (geo_ddr4_i),
    .addr_i     (req_addr_i),
    .bank_o     (dec_bank),
    .row_o      (dec_row),
    .col_o      (dec_col)
  );

  brt_bank_table #(.ROW_W(ROW_W)) u_tbl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .act_i      (act),
    .pre_i      (pre),
    .upd_bank_i (cmd_bank_o),
    .upd_row_i  (cmd_row_o),
    .pall_i     (prechg_all_i),
    .lk_bank_i  (dec_bank),
    .lk_open_o  (lk_open),
    .lk_row_o   (lk_row)
  );

  brt_cmd_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_bank_i   (dec_bank),
    .req_row_i    (dec_row),
    .req_col_i    (dec_col),
    .lk_open_i    (lk_open),
    .lk_row_i     (lk_row),
    .prechg_all_i (prechg_all_i),
    .req_ready_o  (req_ready_o),
    .req_class_o  (cls),
    .cmd_o        (cmd),
    .cmd_bank_o   (cmd_bank_o),
    .cmd_row_o    (cmd_row_o),
    .cmd_col_o    (cmd_col_o),
    .act_o        (act),
    .pre_o        (pre),
    .hit_cnt_o    (hit_cnt_o),
    .miss_cnt_o   (miss_cnt_o)
  );

  assign req_class_o = cls;
  assign cmd_o       = cmd;

  p_ddr3_bank_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!geo_ddr4_i && cmd_o != 3'd0 && $stable(geo_ddr4_i)) |-> !cmd_bank_o[BANK_FIELD_W-1]);
endmodule

// File: tb/bank_row_tracker_tb.sv
module bank_row_tracker_tb_top;
  localparam int ROW_W  = 16;
  localparam int COL_W  = 10;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = ROW_W + 4 + COL_W;

  localparam logic [1:0] C_HIT = 2'd1, C_CONF = 2'd2, C_CLOSED = 2'd3;
  localparam logic [2:0] K_NOP = 3'd0, K_ACT = 3'd1, K_PRE = 3'd2, K_RD = 3'd3, K_WR = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic geo = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic pall = 1'b0;
  logic req_ready;
  logic [1:0] req_class;
  logic [2:0] cmd;
  logic [3:0] cmd_bank;
  logic [ROW_W-1:0] cmd_row;
  logic [COL_W-1:0] cmd_col;
  logic [CNT_W-1:0] hit_cnt, miss_cnt;

  int checks = 0;
  int errors = 0;
  int exp_hits = 0;
  int exp_miss = 0;

  always #5 clk = ~clk;

  bank_row_tracker #(.ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .geo_ddr4_i(geo),
    .req_valid_i(req_valid), .req_write_i(req_write), .req_addr_i(req_addr),
    .prechg_all_i(pall), .req_ready_o(req_ready), .req_class_o(req_class),
    .cmd_o(cmd), .cmd_bank_o(cmd_bank), .cmd_row_o(cmd_row), .cmd_col_o(cmd_col),
    .hit_cnt_o(hit_cnt), .miss_cnt_o(miss_cnt)
  );

  function automatic logic [ADDR_W-1:0] mk(input logic [ROW_W-1:0] r,
                                           input logic [3:0] bf,
                                           input logic [COL_W-1:0] c);
    return {r, bf, c};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one request from an idle sequencer; checks class and full command sequence
  task automatic run_req(input logic [ADDR_W-1:0] a, input logic wr,
                         input logic [1:0] ecls, input logic [3:0] ebank,
                         input string req);
    logic [2:0] seq [3];
    int n;
    logic [2:0] acc;
    acc = wr ? K_WR : K_RD;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = wr;
    #1;
    chk(req_ready == 1'b1, req, "ready idle", int'(req_ready), 1);
    chk(req_class == ecls, req, "class", int'(req_class), int'(ecls));
    if (ecls == C_HIT) begin n = 1; seq[0] = acc; exp_hits++; end
    else if (ecls == C_CLOSED) begin n = 2; seq[0] = K_ACT; seq[1] = acc; end
    else begin n = 3; seq[0] = K_PRE; seq[1] = K_ACT; seq[2] = acc; exp_miss++; end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk(cmd == seq[i], req, "cmd step", int'(cmd), int'(seq[i]));
      chk(cmd_bank == ebank, req, "cmd bank", int'(cmd_bank), int'(ebank));
      if (seq[i] == K_ACT)
        chk(cmd_row == a[ADDR_W-1 -: ROW_W], req, "act row", int'(cmd_row),
            int'(a[ADDR_W-1 -: ROW_W]));
      if (seq[i] == acc)
        chk(cmd_col == a[COL_W-1:0], req, "access col", int'(cmd_col), int'(a[COL_W-1:0]));
      if (i < n - 1)
        chk(req_ready == 1'b0, "R10", "ready during pre/act", int'(req_ready), 0);
      @(negedge clk);
    end
    chk(cmd == K_NOP, req, "idle after access", int'(cmd), int'(K_NOP));
  endtask

  task automatic t_reset();
    #1;
    chk(req_ready == 1'b1, "R9", "ready", int'(req_ready), 1);
    chk(cmd == K_NOP, "R9", "cmd", int'(cmd), 0);
    chk(hit_cnt == 0, "R9", "hit cnt", int'(hit_cnt), 0);
    chk(miss_cnt == 0, "R9", "miss cnt", int'(miss_cnt), 0);
    chk(req_class == 2'd0, "R9", "class idle", int'(req_class), 0);
  endtask

  task automatic t_basic();
    run_req(mk(16'h1234, 4'b0110, 10'h155), 1'b0, C_CLOSED, 4'd6, "R4");
    run_req(mk(16'h1234, 4'b0110, 10'h2AA), 1'b1, C_HIT, 4'd6, "R3");
    run_req(mk(16'h4321, 4'b0110, 10'h011), 1'b0, C_CONF, 4'd6, "R5");
  endtask

  task automatic t_indep();
    // group 2, bank 1 -> index 9
    run_req(mk(16'h1234, 4'b1001, 10'h3FF), 1'b0, C_CLOSED, 4'd9, "R1");
    run_req(mk(16'h4321, 4'b0110, 10'h001), 1'b1, C_HIT, 4'd6, "R6");
    run_req(mk(16'h1234, 4'b1001, 10'h002), 1'b0, C_HIT, 4'd9, "R6");
  endtask

  task automatic t_b2b();
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = mk(16'h4321, 4'b0110, 10'h0AA);
    #1;
    chk(req_class == C_HIT, "R10", "b2b first class", int'(req_class), 1);
    exp_hits++;
    @(posedge clk);
    @(negedge clk);
    chk(cmd == K_RD && cmd_bank == 4'd6, "R10", "b2b first access",
        int'({cmd, cmd_bank}), int'({K_RD, 4'd6}));
    chk(req_ready == 1'b1, "R10", "ready in access cycle", int'(req_ready), 1);
    req_write = 1'b1; req_addr = mk(16'h1234, 4'b1001, 10'h0BB);
    #1;
    chk(req_class == C_HIT, "R10", "b2b second class", int'(req_class), 1);
    exp_hits++;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(cmd == K_WR && cmd_bank == 4'd9 && cmd_col == 10'h0BB, "R10", "b2b second access",
        int'({cmd, cmd_bank}), int'({K_WR, 4'd9}));
  endtask

  task automatic t_pall();
    @(negedge clk);
    pall = 1'b1; req_valid = 1'b1; req_addr = mk(16'h4321, 4'b0110, 10'h0);
    #1;
    chk(req_ready == 1'b0, "R7", "ready during pall", int'(req_ready), 0);
    @(posedge clk);
    @(negedge clk);
    pall = 1'b0; req_valid = 1'b0;
    chk(cmd == K_NOP, "R7", "refused request issues nothing", int'(cmd), 0);
    run_req(mk(16'h4321, 4'b0110, 10'h0), 1'b0, C_CLOSED, 4'd6, "R7");
    run_req(mk(16'h1234, 4'b1001, 10'h0), 1'b0, C_CLOSED, 4'd9, "R7");
  endtask

  task automatic t_ddr3();
    @(negedge clk);
    pall = 1'b1;
    @(negedge clk);
    pall = 1'b0; geo = 1'b0;
    run_req(mk(16'h0007, 4'b1101, 10'h010), 1'b0, C_CLOSED, 4'd5, "R2");
    run_req(mk(16'h0007, 4'b0101, 10'h020), 1'b1, C_HIT, 4'd5, "R2");
    run_req(mk(16'h0008, 4'b1101, 10'h030), 1'b0, C_CONF, 4'd5, "R2");
    geo = 1'b1;
  endtask

  task automatic t_counts();
    @(negedge clk);
    chk(int'(hit_cnt) == exp_hits, "R8", "hit count", int'(hit_cnt), exp_hits);
    chk(int'(miss_cnt) == exp_miss, "R8", "miss count", int'(miss_cnt), exp_miss);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_indep();
    t_b2b();
    t_pall();
    t_ddr3();
    t_counts();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule